// File: doc/BRIEF.md
# Routing Switch Box with Serially Loaded Connection Points

This block sits where a horizontal and a vertical routing channel cross. Each of the four sides (north, east, south, west) carries `W` tracks. A pin is one track on one side. It is either an input, where the outside world drives it, or an output, where the box drives it. Any track can be joined to exactly one track on each of the other three sides through a connection point, so the flexibility is three. Each connection point is switched on by one configuration bit.

The index pairing of the connection points is fixed when the block is elaborated. In the planar pairing, track k meets track k on every side. In the rotating pairing, a corner turn shifts the index by one, modulo `W`, and a straight crossing keeps it. An output pin carries the OR of every enabled input pin wired to it. The box flags an output pin that has more than one enabled input feeding it.

All direction and enable bits sit in a single shift chain. The chain is loaded one bit per accepted beat on a valid/ready stream. The box never holds back a beat once it is out of reset: `cfg_ready` is low only during reset and for the first cycle after it. A beat with `cfg_valid` low is simply not taken. Routing is purely combinational from `trk_in` to `trk_out`.

Top module: `route_switch_box`

## Requirements
- R1: While reset is high and during the first cycle after it, `cfg_ready` is 0; after that it stays 1. Reset clears every configuration bit, so all pins are inputs, `trk_out` is 0 and no conflict is flagged.
- R2: A configuration bit is taken at a clock edge where `cfg_valid` and `cfg_ready` are both 1. Each bit taken shifts the chain from its top index (10·W−1) toward index 0, so after 10·W bits the first bit sent sits at index 0. Edges with `cfg_valid` low leave the configuration unchanged, whatever `cfg_bit` does.
- R3: Chain index s·W+t is the direction bit of track t on side s, with sides numbered N=0, E=1, S=2, W=3. A value of 1 makes the pin an output, and `trk_oe` shows the bit. Pin vectors use the same index s·W+t.
- R4: Chain index 4·W+p·W+k enables connection point k of side pair p. The pairs are p0 N–E, p1 E–S, p2 S–W, p3 W–N, p4 N–S and p5 E–W. The first-named side of each pair is its "a" side and the other is its "b" side.
- R5: With the planar pairing, point k of any pair joins track k on side a to track k on side b.
- R6: With the rotating pairing, point k of a corner pair (p0 to p3) joins track k on side a to track (k+1) mod W on side b. Straight pairs (p4, p5) join track k to track k.
- R7: An output pin is the OR of the `trk_in` values of all pins joined to it through enabled points whose pins are inputs. It follows `trk_in` in the same cycle. Two output pins joined to each other drive nothing into each other.
- R8: An output pin with no enabled input partner drives 0. An input pin always has `trk_out` 0.
- R9: `trk_conflict` of an output pin is 1 when two or more enabled input partners reach it, whatever their data values. `any_conflict` is the OR of all pin flags.
- R10: An input pin never flags a conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Configuration beat present |
| cfg_ready | output | 1 | Box accepts a configuration beat |
| cfg_bit | input | 1 | Configuration bit of the beat |
| trk_in | input | 4·W | Value arriving on each side-track pin |
| trk_out | output | 4·W | Value the box drives on each side-track pin |
| trk_oe | output | 4·W | Pin is an output (direction bit) |
| trk_conflict | output | 4·W | More than one enabled source reaches this output pin |
| any_conflict | output | 1 | OR of all conflict flags |

## Verification
A configuration bit takes effect at the clock edge that accepts it. The routed outputs and conflict flags then follow `trk_in` with no register delay at all. The bench applies each stimulus one nanosecond after a rising edge, after the last configuration beat has been taken. The monitor compares the results at the next falling edge, once the combinational paths have settled. Two instances, one per pairing, get the same stream and data, so every check compares a corner turn against both index rules at the same time.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
  localparam int SIDES = 4;
  localparam int PAIRS = 6;

  typedef enum logic {TOPO_PLANAR, TOPO_WILTON} topo_e;

  // Pair index joining sides s and o: corners 0..3, straights 4 (N-S) and 5 (E-W)
  function automatic int pair_idx(int s, int o);
    if (o == (s + 1) % SIDES) return s;
    if (s == (o + 1) % SIDES) return o;
    return 4 + (s % 2);
  endfunction

  function automatic bit is_corner(int s, int o);
    return pair_idx(s, o) < 4;
  endfunction

  // True when side s is the "a" side of its pair with o
  function automatic bit side_a(int s, int o);
    if (o == (s + 1) % SIDES) return 1'b1;
    if (s == (o + 1) % SIDES) return 1'b0;
    return s < 2;
  endfunction

  // Connection point serving track t of side s toward side o
  function automatic int point_of(int s, int t, int o, int w, topo_e tp);
    if (!is_corner(s, o) || tp == TOPO_PLANAR || side_a(s, o)) return t;
    return (t + w - 1) % w;
  endfunction

  // Track on side o joined to track t of side s
  function automatic int partner_trk(int s, int t, int o, int w, topo_e tp);
    if (!is_corner(s, o) || tp == TOPO_PLANAR) return t;
    if (side_a(s, o)) return (t + 1) % w;
    return (t + w - 1) % w;
  endfunction
endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
  parameter int NBITS = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_bit,
  output logic [NBITS-1:0] cfg_q
);
  logic rdy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (in_valid && rdy_q) cfg_q <= {in_bit, cfg_q[NBITS-1:1]};
    end
  end

  assign in_ready = rdy_q;

  p_ready_up_r1: assert property (@(posedge clk) disable iff (rst)
    !rst |=> in_ready);
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(cfg_q));
  p_enter_top_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> cfg_q[NBITS-1] == $past(in_bit));
endmodule

// File: rtl/sbox_pin.sv
module sbox_pin #(
  parameter int NSRC = 3,
  localparam int CW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            drive_en,
  input  logic [NSRC-1:0] src_req,
  input  logic [NSRC-1:0] src_dat,
  output logic            pin_out,
  output logic            pin_conflict
);
  logic [CW-1:0] n_req;
  logic          hit;

  always_comb begin
    n_req = '0;
    for (int i = 0; i < NSRC; i++) n_req = n_req + CW'(src_req[i]);
  end

  assign hit          = |(src_req & src_dat);
  assign pin_out      = drive_en & hit;
  assign pin_conflict = drive_en & (n_req > CW'(1));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (!drive_en || src_req == '0) |-> !pin_out);
  p_input_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !drive_en |-> !pin_conflict);
  p_conflict_multi_r9: assert property (@(posedge clk) disable iff (rst)
    pin_conflict |-> (drive_en && !$onehot0(src_req)));
  p_single_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (drive_en && $onehot(src_req)) |-> !pin_conflict);
endmodule

// File: rtl/sbox_route.sv
module sbox_route
  import sbox_pkg::*;
#(
  parameter int    W    = 4,
  parameter topo_e TOPO = TOPO_WILTON,
  localparam int NPIN = SIDES * W,
  localparam int NPT  = PAIRS * W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_dir,
  input  logic [NPT-1:0]  pt_en,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_conf
);
  for (genvar s = 0; s < SIDES; s++) begin : g_side
    for (genvar t = 0; t < W; t++) begin : g_trk
      logic [2:0] req;
      logic [2:0] dat;
      for (genvar j = 0; j < 3; j++) begin : g_src
        localparam int O  = (s + 1 + j) % SIDES;
        localparam int P  = pair_idx(s, O);
        localparam int K  = point_of(s, t, O, W, TOPO);
        localparam int PT = O * W + partner_trk(s, t, O, W, TOPO);
        assign req[j] = pt_en[P*W+K] & ~pin_dir[PT];
        assign dat[j] = pin_in[PT];
      end
      sbox_pin #(.NSRC(3)) u_pin (
        .clk         (clk),
        .rst         (rst),
        .drive_en    (pin_dir[s*W+t]),
        .src_req     (req),
        .src_dat     (dat),
        .pin_out     (pin_out[s*W+t]),
        .pin_conflict(pin_conf[s*W+t])
      );
    end
  end
endmodule

// File: rtl/route_switch_box.sv
module route_switch_box
  import sbox_pkg::*;
#(
  parameter int    W    = 4,
  parameter topo_e TOPO = TOPO_WILTON,
  localparam int NPIN  = SIDES * W,
  localparam int NPT   = PAIRS * W,
  localparam int NBITS = NPIN + NPT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_valid,
  output logic            cfg_ready,
  input  logic            cfg_bit,
  input  logic [NPIN-1:0] trk_in,
  output logic [NPIN-1:0] trk_out,
  output logic [NPIN-1:0] trk_oe,
  output logic [NPIN-1:0] trk_conflict,
  output logic            any_conflict
);
  logic [NBITS-1:0] cfg_q;
  logic [NPIN-1:0]  dir_bits;
  logic [NPT-1:0]   en_bits;

  sbox_cfg_chain #(.NBITS(NBITS)) u_chain (
    .clk     (clk),
    .rst     (rst),
    .in_valid(cfg_valid),
    .in_ready(cfg_ready),
    .in_bit  (cfg_bit),
    .cfg_q   (cfg_q)
  );

  assign dir_bits = cfg_q[NPIN-1:0];
  assign en_bits  = cfg_q[NBITS-1:NPIN];

  sbox_route #(.W(W), .TOPO(TOPO)) u_route (
    .clk     (clk),
    .rst     (rst),
    .pin_dir (dir_bits),
    .pt_en   (en_bits),
    .pin_in  (trk_in),
    .pin_out (trk_out),
    .pin_conf(trk_conflict)
  );

  assign trk_oe       = dir_bits;
  assign any_conflict = |trk_conflict;

  p_out_needs_oe_r8: assert property (@(posedge clk) disable iff (rst)
    (trk_out & ~trk_oe) == '0);
  p_flag_needs_oe_r10: assert property (@(posedge clk) disable iff (rst)
    (trk_conflict & ~trk_oe) == '0);
endmodule

// File: tb/tb_route_switch_box.sv
module tb_route_switch_box;
  timeunit 1ns; timeprecision 1ps;

  localparam int W  = 4;
  localparam int NP = 4 * W;
  localparam int NB = 10 * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_valid = 1'b0;
  logic cfg_bit = 1'b0;
  logic [NP-1:0] trk_in = '0;
  logic rdy_w, rdy_p, any_w, any_p;
  logic [NP-1:0] out_w, oe_w, conf_w, out_p, oe_p, conf_p;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  route_switch_box #(.W(W), .TOPO(sbox_pkg::TOPO_WILTON)) dut (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(rdy_w),
    .cfg_bit(cfg_bit), .trk_in(trk_in), .trk_out(out_w), .trk_oe(oe_w),
    .trk_conflict(conf_w), .any_conflict(any_w));

  route_switch_box #(.W(W), .TOPO(sbox_pkg::TOPO_PLANAR)) dut_planar (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(rdy_p),
    .cfg_bit(cfg_bit), .trk_in(trk_in), .trk_out(out_p), .trk_oe(oe_p),
    .trk_conflict(conf_p), .any_conflict(any_p));

  typedef struct {
    logic [NP-1:0] ow, cw, op, cp, oe;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  function automatic int dir_ix(int s, int t); return s * W + t; endfunction
  function automatic int en_ix(int p, int k); return NP + p * W + k; endfunction
  function automatic logic [NP-1:0] b(int i); return NP'(1) << i; endfunction

  task automatic cmp(string tag, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expectations and compares away from the rising edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      cmp(e.tag, "out wilton", out_w, e.ow);
      cmp(e.tag, "conflict wilton", conf_w, e.cw);
      cmp(e.tag, "out planar", out_p, e.op);
      cmp(e.tag, "conflict planar", conf_p, e.cp);
      cmp(e.tag, "oe (R3)", oe_w, e.oe);
      cmp(e.tag, "any_conflict (R9)", NP'(any_w), NP'(|e.cw));
    end
  end

  // Driver: applies inputs and pushes what the requirements predict
  task automatic apply(logic [NP-1:0] din, logic [NP-1:0] ow, logic [NP-1:0] cw,
                       logic [NP-1:0] op, logic [NP-1:0] cp, logic [NP-1:0] oe, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    trk_in = din;
    e.ow = ow; e.cw = cw; e.op = op; e.cp = cp; e.oe = oe; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    #0.5;
  endtask

  task automatic load(logic [NB-1:0] cfg);
    for (int i = 0; i < NB; i++) begin
      @(posedge clk);
      #1;
      cfg_valid = 1'b1;
      cfg_bit = cfg[i];
    end
    @(posedge clk);
    #1;
    cfg_valid = 1'b0;
  endtask

  initial begin
    logic [NB-1:0] cfg_a, cfg_b;
    logic [NP-1:0] oe_a, oe_b;

    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1", "ready in reset", NP'({rdy_w, rdy_p}), NP'(0));
    @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmp("R1", "ready after reset", NP'({rdy_w, rdy_p}), NP'(3));
    apply(b(0) | b(13), '0, '0, '0, '0, '0, "R1 cleared state");

    // Config A: N0,S2,S3 inputs; N2,E0,E1,W0 outputs; points p0k0, p4k2, p2k3
    cfg_a = '0;
    cfg_a[dir_ix(0, 2)] = 1'b1; cfg_a[dir_ix(1, 0)] = 1'b1;
    cfg_a[dir_ix(1, 1)] = 1'b1; cfg_a[dir_ix(3, 0)] = 1'b1;
    cfg_a[en_ix(0, 0)] = 1'b1; cfg_a[en_ix(4, 2)] = 1'b1; cfg_a[en_ix(2, 3)] = 1'b1;
    oe_a = b(2) | b(4) | b(5) | b(12);
    load(cfg_a);
    // Corner N0 reaches E1 only with rotation; S3 wraps to W0 only with rotation
    apply(b(0) | b(10) | b(11), b(2) | b(5) | b(12), '0, b(2) | b(4), '0, oe_a,
          "R5 R6 R7 corner+straight");
    apply(b(0), b(5), '0, b(4), '0, oe_a, "R4 R6 R8 corner only");
    apply(b(10) | b(11), b(2) | b(12), '0, b(2), '0, oe_a, "R6 R8 straight+wrap");

    // Config B: E1 output; N0 and W1 inputs; points p0k0 and p5k1
    cfg_b = '0;
    cfg_b[dir_ix(1, 1)] = 1'b1;
    cfg_b[en_ix(0, 0)] = 1'b1; cfg_b[en_ix(5, 1)] = 1'b1;
    oe_b = b(5);
    load(cfg_b);
    apply(b(0), b(5), b(5), '0, '0, oe_b, "R9 R7 two sources N0 high");
    apply(b(13), b(5), b(5), b(5), '0, oe_b, "R9 R10 two sources W1 high");
    apply('0, '0, b(5), '0, '0, oe_b, "R9 conflict without data");

    // Idle stream with toggling data must not disturb the configuration
    for (int i = 0; i < 12; i++) begin
      @(posedge clk);
      #1 cfg_bit = ~cfg_bit;
    end
    apply(b(13), b(5), b(5), b(5), '0, oe_b, "R2 hold while valid low");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule